// File: doc/BRIEF.md
# Instruction Window Dependency Analyzer

This block collects a small window of already decoded instructions and then works out every ordering constraint inside that window. Each entry is loaded in program order, one per clock. An entry carries at most one destination register, with an enable, and at most two source registers, each with an enable. Before loading, an upstream decoder maps real instructions onto these fields. A load instruction enables its destination and one source, the base register. A store enables no destination and two sources, the data register and the base register.

A start pulse makes the block sweep the window one row per clock. Row i compares entry i with every later entry j that has been loaded. The block fills three square edge matrices: flow (read after write), anti (write after read) and output (write after write). An edge is marked only if no entry strictly between i and j writes the register in question, so a value that has been overwritten in between does not produce a stale edge. When the sweep finishes, the block raises a one-cycle done pulse. The matrices and an "independent" flag then stay fixed until the next accepted start.

Top module: `dep_window`

## Requirements
- R1: While no sweep is running, each cycle with `loadValid` high stores one entry at the next free index, counting from 0. A load is ignored when the window already holds DEPTH entries, and also while a sweep is running.
- R2: Bit i*DEPTH+j of each matrix is the edge from entry i to entry j. Only bits with i < j < (number of loaded entries) can ever be 1.
- R3: The flow matrix marks i→j when entry i enables its destination and entry j enables a source equal to it, with no entry k, i<k<j, writing that register.
- R4: The anti matrix marks i→j when entry j enables its destination, entry i enables a source equal to it, and no entry k, i<k<j, writes that register.
- R5: The output matrix marks i→j when both entries enable equal destinations and no entry k, i<k<j, writes that register.
- R6: A start sampled while idle begins a sweep. `done` is high for exactly one cycle, DEPTH clock edges after the edge that sampled the start. A start sampled during a sweep is ignored.
- R7: During `done` and afterwards, `independent` is 1 exactly when all three matrices are zero.
- R8: The edge that accepts a start clears all three matrices and `independent`. From `done` until the next accepted start, the results do not change, even while new entries are being loaded.
- R9: After `done`, the window is empty, and the next load goes to index 0.
- R10: After reset, `done` and `independent` are 0, all matrices are zero, and the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadValid | input | 1 | Append the presented entry to the window |
| dstEn | input | 1 | Entry writes a destination register |
| dstReg | input | REG_W | Destination register number |
| srcAEn | input | 1 | First source is read |
| srcAReg | input | REG_W | First source register number |
| srcBEn | input | 1 | Second source is read |
| srcBReg | input | REG_W | Second source register number |
| start | input | 1 | Begin a sweep over the loaded entries |
| done | output | 1 | One-cycle pulse: results are complete |
| rawEdges | output | DEPTH*DEPTH | Flow edges, bit i*DEPTH+j |
| warEdges | output | DEPTH*DEPTH | Anti edges, bit i*DEPTH+j |
| wawEdges | output | DEPTH*DEPTH | Output edges, bit i*DEPTH+j |
| independent | output | 1 | No edge of any kind in the finished window |

## Verification
An entry loaded at one edge is part of the window from that edge on. The matrices are zero in the cycle right after the edge that accepts a start. `done` is low after edges one through DEPTH-1 of the sweep and high after edge DEPTH. The matrices and `independent` are compared against an arithmetic model in that same cycle, and `done` must be low again one edge later. All samples are taken 1 ns after a rising edge, and inputs change on falling edges. The sweep timing is therefore checked to the exact cycle. That includes windows in which a load or a second start arrives in the middle of a sweep.

// File: rtl/dep_pkg.sv
package dep_pkg;
  // strobes from the sequencer to the compare datapath
  typedef struct packed {
    logic wrEntry;   // store presented entry at wrIdx
    logic clearRes;  // wipe matrices at sweep start
    logic scanEn;    // write one row of results
    logic lastRow;   // current row is the final one
  } dep_strobe_t;
endpackage

// File: rtl/dep_ctrl.sv
module dep_ctrl
  import dep_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic             start,
  output dep_strobe_t      strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] row,
  output logic [CNT_W-1:0] fill,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_t;

  state_t           stateQ;
  logic [CNT_W-1:0] fillQ;
  logic [IDX_W-1:0] rowQ;
  logic             doneQ;

  always_comb begin
    strobe.wrEntry  = (stateQ == ST_IDLE) && loadValid && (fillQ < CNT_W'(DEPTH));
    strobe.clearRes = (stateQ == ST_IDLE) && start;
    strobe.scanEn   = (stateQ == ST_SCAN);
    strobe.lastRow  = (stateQ == ST_SCAN) && (rowQ == IDX_W'(DEPTH - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      fillQ  <= '0;
      rowQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.lastRow;
      if (strobe.wrEntry) fillQ <= fillQ + 1'b1;
      if (strobe.clearRes) begin
        stateQ <= ST_SCAN;
        rowQ   <= '0;
      end else if (strobe.scanEn) begin
        rowQ <= rowQ + 1'b1;
        if (strobe.lastRow) begin
          stateQ <= ST_IDLE;
          fillQ  <= '0;
        end
      end
    end
  end

  assign wrIdx = IDX_W'(fillQ);
  assign row   = rowQ;
  assign fill  = fillQ;
  assign done  = doneQ;
endmodule

// File: rtl/dep_path.sv
module dep_path
  import dep_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int REG_W = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int MAT_W = DEPTH * DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  dep_strobe_t      strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] row,
  input  logic [CNT_W-1:0] fill,
  input  logic             dstEn,
  input  logic [REG_W-1:0] dstReg,
  input  logic             srcAEn,
  input  logic [REG_W-1:0] srcAReg,
  input  logic             srcBEn,
  input  logic [REG_W-1:0] srcBReg,
  output logic [MAT_W-1:0] rawEdges,
  output logic [MAT_W-1:0] warEdges,
  output logic [MAT_W-1:0] wawEdges,
  output logic             independent
);
  logic             wrQ   [DEPTH];
  logic [REG_W-1:0] dstQ  [DEPTH];
  logic             aEnQ  [DEPTH];
  logic [REG_W-1:0] aQ    [DEPTH];
  logic             bEnQ  [DEPTH];
  logic [REG_W-1:0] bQ    [DEPTH];

  logic [DEPTH-1:0] sameDst [DEPTH];
  logic [DEPTH-1:0] rawRow, warRow, wawRow;
  logic [MAT_W-1:0] rawQ, warQ, wawQ;
  logic             indepQ;

  // entry storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) begin
        wrQ[e]  <= 1'b0;
        dstQ[e] <= '0;
        aEnQ[e] <= 1'b0;
        aQ[e]   <= '0;
        bEnQ[e] <= 1'b0;
        bQ[e]   <= '0;
      end
    end else if (strobe.wrEntry) begin
      wrQ[wrIdx]  <= dstEn;
      dstQ[wrIdx] <= dstReg;
      aEnQ[wrIdx] <= srcAEn;
      aQ[wrIdx]   <= srcAReg;
      bEnQ[wrIdx] <= srcBEn;
      bQ[wrIdx]   <= srcBReg;
    end
  end

  // pairwise destination collisions
  always_comb begin
    for (int a = 0; a < DEPTH; a++)
      for (int b = 0; b < DEPTH; b++)
        sameDst[a][b] = wrQ[a] && wrQ[b] && (dstQ[a] == dstQ[b]);
  end

  // one row of edges: current entry against every later loaded entry
  always_comb begin
    logic inWin, killOld, killNew, readsOld, newHitsOld;
    for (int j = 0; j < DEPTH; j++) begin
      inWin   = (j > int'(row)) && (j < int'(fill));
      killOld = 1'b0;
      killNew = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
        if ((k > int'(row)) && (k < j)) begin
          killOld = killOld | sameDst[row][k];
          killNew = killNew | sameDst[k][j];
        end
      end
      readsOld   = (aEnQ[j] && (aQ[j] == dstQ[row])) ||
                   (bEnQ[j] && (bQ[j] == dstQ[row]));
      newHitsOld = (aEnQ[row] && (aQ[row] == dstQ[j])) ||
                   (bEnQ[row] && (bQ[row] == dstQ[j]));
      rawRow[j] = inWin && wrQ[row] && readsOld && !killOld;
      warRow[j] = inWin && wrQ[j] && newHitsOld && !killNew;
      wawRow[j] = inWin && sameDst[row][j] && !killOld;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ   <= '0;
      warQ   <= '0;
      wawQ   <= '0;
      indepQ <= 1'b0;
    end else if (strobe.clearRes) begin
      rawQ   <= '0;
      warQ   <= '0;
      wawQ   <= '0;
      indepQ <= 1'b0;
    end else if (strobe.scanEn) begin
      rawQ[int'(row)*DEPTH +: DEPTH] <= rawRow;
      warQ[int'(row)*DEPTH +: DEPTH] <= warRow;
      wawQ[int'(row)*DEPTH +: DEPTH] <= wawRow;
      if (strobe.lastRow)
        indepQ <= !((|rawQ) || (|warQ) || (|wawQ) ||
                    (|rawRow) || (|warRow) || (|wawRow));
    end
  end

  assign rawEdges    = rawQ;
  assign warEdges    = warQ;
  assign wawEdges    = wawQ;
  assign independent = indepQ;
endmodule

// File: rtl/dep_window.sv
module dep_window
  import dep_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int REG_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadValid,
  input  logic                     dstEn,
  input  logic [REG_W-1:0]         dstReg,
  input  logic                     srcAEn,
  input  logic [REG_W-1:0]         srcAReg,
  input  logic                     srcBEn,
  input  logic [REG_W-1:0]         srcBReg,
  input  logic                     start,
  output logic                     done,
  output logic [DEPTH*DEPTH-1:0]   rawEdges,
  output logic [DEPTH*DEPTH-1:0]   warEdges,
  output logic [DEPTH*DEPTH-1:0]   wawEdges,
  output logic                     independent
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  dep_strobe_t      strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] row;
  logic [CNT_W-1:0] fill;

  dep_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .start(start),
    .strobe(strobe), .wrIdx(wrIdx), .row(row), .fill(fill), .done(done)
  );

  dep_path #(.DEPTH(DEPTH), .REG_W(REG_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .row(row),
    .fill(fill), .dstEn(dstEn), .dstReg(dstReg), .srcAEn(srcAEn),
    .srcAReg(srcAReg), .srcBEn(srcBEn), .srcBReg(srcBReg),
    .rawEdges(rawEdges), .warEdges(warEdges), .wawEdges(wawEdges),
    .independent(independent)
  );
endmodule

// File: rtl/dep_window_chk.sv
module dep_window_chk #(
  parameter int DEPTH = 6,
  localparam int MAT_W = DEPTH * DEPTH
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic [MAT_W-1:0] rawEdges,
  input logic [MAT_W-1:0] warEdges,
  input logic [MAT_W-1:0] wawEdges,
  input logic             independent
);
  function automatic logic [MAT_W-1:0] notUpper();
    logic [MAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j <= i; j++)
        m[i*DEPTH + j] = 1'b1;
    return m;
  endfunction

  localparam logic [MAT_W-1:0] BAD_MASK = notUpper();

  logic heldQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      heldQ <= 1'b0;
    else if (start) heldQ <= 1'b0;
    else if (done)  heldQ <= 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((rawEdges | warEdges | wawEdges) & BAD_MASK) == '0); // R2
  AST_INDEP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (independent == ((rawEdges | warEdges | wawEdges) == '0))); // R7
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rstN)
    (heldQ && !start) |=> ($stable(rawEdges) && $stable(warEdges) &&
                           $stable(wawEdges) && $stable(independent))); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (heldQ && start) |=> (rawEdges == '0 && warEdges == '0 &&
                          wawEdges == '0 && !independent)); // R8
endmodule

bind dep_window dep_window_chk #(.DEPTH(DEPTH)) u_dep_window_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .rawEdges(rawEdges), .warEdges(warEdges), .wawEdges(wawEdges),
  .independent(independent)
);

// File: tb/test_dep_window.sv
module test_dep_window;
  localparam int N = 6;
  localparam int RW = 5;
  localparam int MW = N * N;

  logic          clk = 0;
  logic          rstN = 0;
  logic          loadValid = 0, dstEn = 0, srcAEn = 0, srcBEn = 0, start = 0;
  logic [RW-1:0] dstReg = '0, srcAReg = '0, srcBReg = '0;
  logic          done, independent;
  logic [MW-1:0] rawEdges, warEdges, wawEdges;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench model of the window
  int mCnt = 0;
  bit mW [N];
  int mD [N];
  bit mAE [N];
  int mA [N];
  bit mBE [N];
  int mB [N];
  logic [MW-1:0] expRaw, expWar, expWaw;

  always #5 clk = ~clk;

  dep_window #(.DEPTH(N), .REG_W(RW)) i_dep_window (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .dstEn(dstEn),
    .dstReg(dstReg), .srcAEn(srcAEn), .srcAReg(srcAReg), .srcBEn(srcBEn),
    .srcBReg(srcBReg), .start(start), .done(done), .rawEdges(rawEdges),
    .warEdges(warEdges), .wawEdges(wawEdges), .independent(independent)
  );

  task automatic chk(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit writesSame(int x, int y);
    return mW[x] && mW[y] && (mD[x] == mD[y]);
  endfunction

  task automatic buildExpected();
    expRaw = '0; expWar = '0; expWaw = '0;
    for (int i = 0; i < mCnt; i++)
      for (int j = i + 1; j < mCnt; j++) begin
        bit hitOld, hitNew;
        hitOld = 0; hitNew = 0;
        for (int k = i + 1; k < j; k++) begin
          if (writesSame(i, k)) hitOld = 1;
          if (writesSame(k, j)) hitNew = 1;
        end
        if (mW[i] && !hitOld && ((mAE[j] && mA[j] == mD[i]) || (mBE[j] && mB[j] == mD[i])))
          expRaw[i*N+j] = 1'b1;
        if (mW[j] && !hitNew && ((mAE[i] && mA[i] == mD[j]) || (mBE[i] && mB[i] == mD[j])))
          expWar[i*N+j] = 1'b1;
        if (writesSame(i, j) && !hitOld)
          expWaw[i*N+j] = 1'b1;
      end
  endtask

  task automatic loadOne(input bit w, input int d, input bit ae, input int a,
                         input bit be, input int b);
    @(negedge clk);
    loadValid = 1; dstEn = w; dstReg = RW'(d);
    srcAEn = ae; srcAReg = RW'(a); srcBEn = be; srcBReg = RW'(b);
    @(posedge clk); #1;
    loadValid = 0;
    if (mCnt < N) begin
      mW[mCnt] = w; mD[mCnt] = d; mAE[mCnt] = ae; mA[mCnt] = a;
      mBE[mCnt] = be; mB[mCnt] = b;
      mCnt++;
    end
  endtask

  // sweep and compare; poke = load and start again during the sweep
  task automatic sweep(input string tag, input bit poke);
    logic [MW-1:0] outside;
    buildExpected();
    outside = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (!(i < j && j < mCnt)) outside[i*N+j] = 1'b1;
    @(negedge clk); start = 1;
    @(posedge clk); #1; start = 0;
    chk({tag, " R8 cleared at start"}, rawEdges | warEdges | wawEdges, '0);
    chk({tag, " R8 indep cleared"}, MW'(independent), '0);
    if (poke) begin
      @(negedge clk);
      start = 1; loadValid = 1; dstEn = 1; dstReg = RW'(mD[0] ^ 1);
      srcAEn = 1; srcAReg = RW'(mD[0]); srcBEn = 1; srcBReg = RW'(mD[1]);
      @(posedge clk); #1;
      start = 0; loadValid = 0;
      repeat (N - 2) @(posedge clk);
    end else begin
      repeat (N - 1) @(posedge clk);
    end
    #1;
    chk({tag, " R6 done not early"}, MW'(done), '0);
    @(posedge clk); #1;
    chk({tag, " R6 done on time"}, MW'(done), MW'(1));
    chk({tag, " R3 flow"}, rawEdges, expRaw);
    chk({tag, " R4 anti"}, warEdges, expWar);
    chk({tag, " R5 output"}, wawEdges, expWaw);
    chk({tag, " R2 outside triangle"}, (rawEdges | warEdges | wawEdges) & outside, '0);
    chk({tag, " R7 independent"}, MW'(independent),
        MW'((expRaw | expWar | expWaw) == '0));
    @(posedge clk); #1;
    chk({tag, " R6 done one cycle"}, MW'(done), '0);
    mCnt = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] keep;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset done", MW'(done), '0);
    chk("R10 reset matrices", rawEdges | warEdges | wawEdges, '0);
    chk("R10 reset indep", MW'(independent), '0);
    @(negedge clk); rstN = 1;

    // dependent chain with overwrite in the middle
    loadOne(1, 2, 1, 1, 1, 0);
    loadOne(1, 4, 1, 2, 1, 3);
    loadOne(1, 2, 1, 2, 1, 4);
    loadOne(1, 4, 1, 2, 1, 6);
    sweep("chain", 0);
    chk("R3 chain hand", rawEdges, MW'((1 << 1) | (1 << 2) | (1 << 8) | (1 << 15)));
    chk("R4 chain hand", warEdges, MW'((1 << 8) | (1 << 15)));
    chk("R5 chain hand", wawEdges, MW'((1 << 2) | (1 << 9)));

    // two copies of load/add/store, same registers (base reg 31)
    for (int c = 0; c < 2; c++) begin
      loadOne(1, 0, 1, 31, 0, 0);
      loadOne(1, 4, 1, 0, 1, 2);
      loadOne(0, 0, 1, 4, 1, 31);
    end
    sweep("R9 unrolled", 0);
    chk("R3 unrolled hand", rawEdges, MW'((1 << 1) | (1 << 8) | (1 << 22) | (1 << 29)));
    chk("R5 unrolled hand", wawEdges, MW'((1 << 3) | (1 << 10)));
    chk("R4 unrolled hand", warEdges, MW'((1 << 9) | (1 << 16)));

    // renamed second copy: only flow edges
    loadOne(1, 0, 1, 31, 0, 0);  loadOne(1, 4, 1, 0, 1, 2);  loadOne(0, 0, 1, 4, 1, 31);
    loadOne(1, 6, 1, 31, 0, 0);  loadOne(1, 8, 1, 6, 1, 2);  loadOne(0, 0, 1, 8, 1, 31);
    sweep("renamed", 0);
    chk("R4 renamed no anti", warEdges, '0);
    chk("R5 renamed no output", wawEdges, '0);

    // fully independent window
    loadOne(1, 1, 1, 9, 1, 10); loadOne(1, 2, 1, 11, 0, 0); loadOne(1, 3, 0, 0, 1, 12);
    sweep("indep", 0);
    chk("R7 indep high", MW'(independent), MW'(1));

    // empty window
    sweep("R9 empty", 0);
    chk("R7 empty indep", MW'(independent), MW'(1));

    // seventh load would collide with entry 0
    for (int e = 0; e < N; e++) loadOne(1, 10 + e, 1, 20, 0, 0);
    loadOne(1, 10, 1, 10, 1, 11);
    sweep("R1 overflow ignored", 0);

    // load and start during a sweep are ignored
    loadOne(1, 1, 0, 0, 0, 0); loadOne(1, 2, 0, 0, 0, 0); loadOne(1, 3, 0, 0, 0, 0);
    sweep("R1 R6 busy poke", 1);

    // results held while a new window loads, then cleared by start
    loadOne(1, 5, 0, 0, 0, 0); loadOne(1, 6, 1, 5, 0, 0);
    sweep("hold", 0);
    keep = rawEdges;
    loadOne(1, 7, 1, 6, 0, 0);
    loadOne(1, 7, 1, 7, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R8 held", rawEdges, keep);
    sweep("R1 R9 after hold", 0);

    // sweep over random windows drawn from a small register space
    for (int t = 0; t < 400; t++) begin
      int n;
      n = $urandom_range(0, N);
      for (int e = 0; e < n; e++)
        loadOne($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1),
                $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3));
      sweep("sweep", 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule